// File: doc/BRIEF.md
# OTP Patch-Record Map Decoder

This block turns the raw contents of a byte-wide one-time-programmable array into a 512-byte logical configuration map. The array holds a packed list of patch records. Each record starts with a header naming a section of the map and a mask of the words it carries, followed by the data bytes of those words. A pulse on `start` makes the block walk the array from physical address 0. It reads one byte per request through a synchronous port whose data returns one cycle after the address. Each data byte is written into an internal map store.

Every logical word starts out erased (0xFFFF) at the start of each walk. Records are applied in array order, so a later record for the same word replaces an earlier one. When the walk ends, the block pulses `done`, reports whether the array was blank and how many physical bytes the walk consumed, and a consumer reads the rebuilt map one byte at a time through a registered read port.

Top module: `otp_map_decoder`

## Requirements
- R1: After reset, busy, done, empty and used_count are 0 and every logical map byte reads 0xFF.
- R2: A start pulse while idle raises busy on the next cycle and erases the whole map. The walk ends with done high for exactly one cycle with busy already low, and any logical byte no record wrote reads 0xFF.
- R3: If physical byte 0 reads 0xFF, the walk ends with empty=1 and used_count=0, and the map stays all 0xFF.
- R4: A header byte whose bits 4:0 are not 5'b01111 is short: bits 7:4 are the section and bits 3:0 are an active-low word mask. Present words are taken in order from word 0 to word 3, two bytes each, low byte first. They are stored at logical address section*8 + word*2 + byte (0 low, 1 high).
- R5: A header byte with bits 4:0 equal to 5'b01111 is extended. Its section is {second byte bits 7:4, first byte bits 7:5} and its word mask is bits 3:0 of the second byte.
- R6: An extended header whose second byte has bits 3:0 equal to 4'hF carries no data. The byte after it is decoded as a header.
- R7: A record whose section is 64 or above writes nothing and consumes no data bytes. The byte after its header is decoded as a header.
- R8: The walk stops at a header byte of 0xFF. used_count then equals that byte's physical address, and no further array reads follow.
- R9: No array read is issued at or above the content limit (default 256), and reaching it ends the walk with used_count equal to the limit. A word cut off after its low byte reads 0x00 as its high byte.
- R10: When two records carry the same section and word, the map holds the data of the later one.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | One-cycle request to rebuild the map; taken only while idle |
| busy | output | 1 | High while the walk runs |
| done | output | 1 | One-cycle pulse when the walk ends |
| empty | output | 1 | Last walk found a blank array (byte 0 erased) |
| used_count | output | 9 | Physical bytes consumed by the last walk |
| otp_rd_en | output | 1 | Array read request |
| otp_addr | output | 9 | Array byte address of the request |
| otp_rdata | input | 8 | Array data, valid the cycle after the request |
| map_raddr | input | 9 | Logical map byte address |
| map_rdata | output | 8 | Logical map byte, registered one cycle after map_raddr |

## Verification
On every cycle, the embedded assertions check the handshake shape: done is a single-cycle pulse that follows busy. They also check that a map write always follows an array read, that a high byte is never stored before its low byte, and that the byte count stays within the limit and holds still between walks. The bench drives a walker-independent model that predicts the exact sequence of array addresses. It compares each read as it happens, so skipped extended records, out-of-range sections and the stop conditions show up in the address stream. Header decoding, section arithmetic, last-write-wins, the zeroed high byte of a truncated word and the erase between walks are shown only by the scenarios, which read back all 512 map bytes after each walk.

// File: rtl/otp_map_pkg.sv
package otp_map_pkg;
   typedef enum logic [2:0] {
      W_IDLE,
      W_HDR_RD,
      W_HDR,
      W_EXT_RD,
      W_EXT,
      W_DAT_RD,
      W_DAT
   } walk_state_e;

   localparam int          WORDS_PER_SEC = 4;
   localparam logic [7:0]  ERASED_BYTE   = 8'hFF;
   localparam logic [4:0]  LONG_TAG      = 5'h0F;
   localparam logic [3:0]  NO_WORDS      = 4'hF;
endpackage

// File: rtl/otp_rec_walker.sv
module otp_rec_walker
   import otp_map_pkg::*;
#(
   parameter int PHYS_AW       = 9,
   parameter int CONTENT_LIMIT = 256,
   parameter int SEC_BITS      = 6,
   localparam int CNT_W        = $clog2(CONTENT_LIMIT + 1),
   localparam int MAP_AW       = SEC_BITS + 3
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   output logic              otp_rd_en,
   output logic [PHYS_AW-1:0] otp_addr,
   input  logic [7:0]        otp_rdata,
   output logic              map_clear,
   output logic              map_we,
   output logic [MAP_AW-1:0] map_waddr,
   output logic [7:0]        map_wdata,
   output logic              busy,
   output logic              done,
   output logic              empty,
   output logic [CNT_W-1:0]  used_count
);
   localparam int SECTIONS = 1 << SEC_BITS;
   localparam int PW       = (CNT_W > PHYS_AW) ? CNT_W : PHYS_AW;
   localparam logic [PW-1:0] LIM_V = PW'(CONTENT_LIMIT);

   walk_state_e      state_q;
   logic [PW-1:0]    ptr_q;
   logic [2:0]       hi3_q;
   logic [6:0]       sec_q;
   logic [3:0]       pres_q;
   logic             half_q;
   logic             empty_q;
   logic             done_q;
   logic [CNT_W-1:0] used_q;

   logic             at_lim;
   logic [1:0]       cur_word;
   logic [3:0]       pres_left;
   logic [6:0]       short_sec;
   logic [6:0]       long_sec;

   function automatic logic in_map(input logic [6:0] s);
      return ({1'b0, s} < 8'(SECTIONS));
   endfunction

   assign at_lim    = (ptr_q >= LIM_V);
   assign short_sec = {3'b000, otp_rdata[7:4]};
   assign long_sec  = {otp_rdata[7:4], hi3_q};

   // lowest still-pending word of the current record
   always_comb begin
      cur_word = 2'd0;
      for (int i = WORDS_PER_SEC - 1; i >= 0; i--) begin
         if (pres_q[i]) cur_word = 2'(i);
      end
   end
   assign pres_left = pres_q & ~(4'b0001 << cur_word);

   assign otp_rd_en  = ((state_q == W_HDR_RD) || (state_q == W_EXT_RD) ||
                        (state_q == W_DAT_RD)) && !at_lim;
   assign otp_addr   = ptr_q[PHYS_AW-1:0];
   assign map_clear  = (state_q == W_IDLE) && start;
   assign map_we     = (state_q == W_DAT);
   assign map_waddr  = {sec_q[SEC_BITS-1:0], cur_word, half_q};
   assign map_wdata  = otp_rdata;
   assign busy       = (state_q != W_IDLE);
   assign done       = done_q;
   assign empty      = empty_q;
   assign used_count = used_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= W_IDLE;
         ptr_q   <= '0;
         hi3_q   <= '0;
         sec_q   <= '0;
         pres_q  <= '0;
         half_q  <= 1'b0;
         empty_q <= 1'b0;
         done_q  <= 1'b0;
         used_q  <= '0;
      end else begin
         done_q <= 1'b0;
         case (state_q)
            W_IDLE: begin
               if (start) begin
                  ptr_q   <= '0;
                  empty_q <= 1'b0;
                  used_q  <= '0;
                  state_q <= W_HDR_RD;
               end
            end
            W_HDR_RD, W_EXT_RD, W_DAT_RD: begin
               if (at_lim) begin
                  state_q <= W_IDLE;
                  done_q  <= 1'b1;
                  used_q  <= ptr_q[CNT_W-1:0];
               end else if (state_q == W_HDR_RD) begin
                  state_q <= W_HDR;
               end else if (state_q == W_EXT_RD) begin
                  state_q <= W_EXT;
               end else begin
                  state_q <= W_DAT;
               end
            end
            W_HDR: begin
               if (otp_rdata == ERASED_BYTE) begin
                  state_q <= W_IDLE;
                  done_q  <= 1'b1;
                  used_q  <= ptr_q[CNT_W-1:0];
                  empty_q <= (ptr_q == '0);
               end else begin
                  ptr_q <= ptr_q + PW'(1);
                  if (otp_rdata[4:0] == LONG_TAG) begin
                     hi3_q   <= otp_rdata[7:5];
                     state_q <= W_EXT_RD;
                  end else begin
                     sec_q   <= short_sec;
                     pres_q  <= ~otp_rdata[3:0];
                     half_q  <= 1'b0;
                     state_q <= (in_map(short_sec) && otp_rdata[3:0] != NO_WORDS) ?
                                W_DAT_RD : W_HDR_RD;
                  end
               end
            end
            W_EXT: begin
               ptr_q <= ptr_q + PW'(1);
               if (otp_rdata[3:0] == NO_WORDS) begin
                  state_q <= W_HDR_RD;
               end else begin
                  sec_q   <= long_sec;
                  pres_q  <= ~otp_rdata[3:0];
                  half_q  <= 1'b0;
                  state_q <= in_map(long_sec) ? W_DAT_RD : W_HDR_RD;
               end
            end
            W_DAT: begin
               ptr_q <= ptr_q + PW'(1);
               if (!half_q) begin
                  half_q  <= 1'b1;
                  state_q <= W_DAT_RD;
               end else begin
                  half_q  <= 1'b0;
                  pres_q  <= pres_left;
                  state_q <= (pres_left == 4'b0000) ? W_HDR_RD : W_DAT_RD;
               end
            end
            default: state_q <= W_IDLE;
         endcase
      end
   end

   // R2
   done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);
   // R2
   done_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> (!busy && $past(busy)));
   // R3
   empty_used_chk: assert property (@(posedge clk) disable iff (!rst_n)
      empty |-> (used_count == '0));
   // R4
   we_after_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
      map_we |-> $past(otp_rd_en));
   // R8
   used_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!busy && !start) |=> $stable(used_count));
   // R9
   used_lim_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> ({1'b0, used_count} <= (CNT_W + 1)'(CONTENT_LIMIT)));
endmodule

// File: rtl/otp_map_store.sv
module otp_map_store
   import otp_map_pkg::*;
#(
   parameter int SEC_BITS   = 6,
   parameter bit READ_REG   = 1'b1,
   localparam int MAP_AW    = SEC_BITS + 3
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              clear,
   input  logic              we,
   input  logic [MAP_AW-1:0] waddr,
   input  logic [7:0]        wdata,
   input  logic [MAP_AW-1:0] raddr,
   output logic [7:0]        rdata
);
   localparam int NWORDS = (1 << SEC_BITS) * WORDS_PER_SEC;
   localparam int WIDX_W = MAP_AW - 1;

   logic [15:0]       word_q [NWORDS];
   logic [NWORDS-1:0] vld_q;
   logic [WIDX_W-1:0] widx;
   logic [WIDX_W-1:0] ridx;
   logic [7:0]        rd_byte;

   assign widx = waddr[MAP_AW-1:1];
   assign ridx = raddr[MAP_AW-1:1];

   // low byte opens the word and zeroes its high half
   always_ff @(posedge clk) begin
      if (we) begin
         if (!waddr[0]) word_q[widx] <= {8'h00, wdata};
         else           word_q[widx][15:8] <= wdata;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                 vld_q <= '0;
      else if (clear)             vld_q <= '0;
      else if (we && !waddr[0])   vld_q[widx] <= 1'b1;
   end

   assign rd_byte = !vld_q[ridx] ? ERASED_BYTE :
                    (raddr[0] ? word_q[ridx][15:8] : word_q[ridx][7:0]);

   generate
      if (READ_REG) begin : g_rd_reg
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) rdata <= ERASED_BYTE;
            else        rdata <= rd_byte;
         end
      end else begin : g_rd_comb
         assign rdata = rd_byte;
      end
   endgenerate

   // R4
   hi_after_lo_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (we && waddr[0]) |-> vld_q[widx]);
   // R2
   no_write_on_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      clear |-> !we);
endmodule

// File: rtl/otp_map_decoder.sv
module otp_map_decoder #(
   parameter int PHYS_AW       = 9,
   parameter int CONTENT_LIMIT = 256,
   parameter int SEC_BITS      = 6,
   parameter bit READ_REG      = 1'b1,
   localparam int CNT_W        = $clog2(CONTENT_LIMIT + 1),
   localparam int MAP_AW       = SEC_BITS + 3
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               start,
   output logic               busy,
   output logic               done,
   output logic               empty,
   output logic [CNT_W-1:0]   used_count,
   output logic               otp_rd_en,
   output logic [PHYS_AW-1:0] otp_addr,
   input  logic [7:0]         otp_rdata,
   input  logic [MAP_AW-1:0]  map_raddr,
   output logic [7:0]         map_rdata
);
   generate
      if (SEC_BITS < 1 || SEC_BITS > 7) begin : g_bad_sec
         $error("SEC_BITS must lie in 1..7");
      end
      if (CONTENT_LIMIT < 1 || CONTENT_LIMIT > (1 << PHYS_AW)) begin : g_bad_lim
         $error("CONTENT_LIMIT must lie in 1..2**PHYS_AW");
      end
   endgenerate

   logic              clr;
   logic              we;
   logic [MAP_AW-1:0] waddr;
   logic [7:0]        wdata;

   otp_rec_walker #(
      .PHYS_AW       (PHYS_AW),
      .CONTENT_LIMIT (CONTENT_LIMIT),
      .SEC_BITS      (SEC_BITS)
   ) u_walker (
      .clk        (clk),
      .rst_n      (rst_n),
      .start      (start),
      .otp_rd_en  (otp_rd_en),
      .otp_addr   (otp_addr),
      .otp_rdata  (otp_rdata),
      .map_clear  (clr),
      .map_we     (we),
      .map_waddr  (waddr),
      .map_wdata  (wdata),
      .busy       (busy),
      .done       (done),
      .empty      (empty),
      .used_count (used_count)
   );

   otp_map_store #(
      .SEC_BITS (SEC_BITS),
      .READ_REG (READ_REG)
   ) u_store (
      .clk   (clk),
      .rst_n (rst_n),
      .clear (clr),
      .we    (we),
      .waddr (waddr),
      .wdata (wdata),
      .raddr (map_raddr),
      .rdata (map_rdata)
   );
endmodule

// File: tb/otp_map_decoder_tb.sv
module otp_map_decoder_tb;
   localparam int LIM = 256;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       start = 1'b0;
   logic       busy, done, empty, otp_rd_en;
   logic [8:0] used_count, otp_addr, map_raddr;
   logic [7:0] otp_rdata, map_rdata;
   logic [7:0] otp_q = 8'hFF;
   logic [7:0] img [512];

   int checks = 0;
   int errors = 0;
   int exp_map [512];
   int exp_used;
   bit exp_empty;
   int addr_q [$];

   always #5 clk = ~clk;

   otp_map_decoder u_dut (
      .clk(clk), .rst_n(rst_n), .start(start), .busy(busy), .done(done),
      .empty(empty), .used_count(used_count), .otp_rd_en(otp_rd_en),
      .otp_addr(otp_addr), .otp_rdata(otp_rdata), .map_raddr(map_raddr),
      .map_rdata(map_rdata)
   );

   // array model: data one cycle after the request
   always @(posedge clk) if (otp_rd_en) otp_q <= img[otp_addr];
   assign otp_rdata = otp_q;

   // every read compared against the predicted address stream (R8, R9)
   always @(negedge clk) begin
      if (rst_n && otp_rd_en) begin
         checks++;
         if (addr_q.size() == 0) begin
            errors++;
            $display("FAIL R8 read sequence: actual addr %0d expected none", otp_addr);
         end else begin
            if (int'(otp_addr) != addr_q[0]) begin
               errors++;
               $display("FAIL R9 read sequence: actual addr %0d expected %0d",
                        otp_addr, addr_q[0]);
            end
            void'(addr_q.pop_front());
         end
      end
   end

   task automatic check(string tag, int act, int expv, string what);
      checks++;
      if (act != expv) begin
         errors++;
         $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, expv);
      end
   endtask

   // behavioural walk of the record format
   task automatic model();
      int p = 0;
      bit stop = 0;
      for (int a = 0; a < 512; a++) exp_map[a] = 255;
      exp_empty = 0;
      addr_q.delete();
      while (!stop) begin
         int b, c, sec, m;
         if (p >= LIM) break;
         addr_q.push_back(p);
         b = int'(img[p]);
         if (b == 255) begin
            exp_empty = (p == 0);
            break;
         end
         p++;
         if ((b & 31) == 15) begin
            if (p >= LIM) break;
            addr_q.push_back(p);
            c = int'(img[p]);
            p++;
            if ((c & 15) == 15) continue;
            sec = ((c >> 4) << 3) | (b >> 5);
            m = c & 15;
         end else begin
            sec = b >> 4;
            m = b & 15;
         end
         if (sec >= 64) continue;
         for (int w = 0; w < 4 && !stop; w++) begin
            if (((m >> w) & 1) == 0) begin
               for (int h = 0; h < 2; h++) begin
                  int la;
                  if (p >= LIM) begin stop = 1; break; end
                  addr_q.push_back(p);
                  la = sec * 8 + w * 2 + h;
                  exp_map[la] = int'(img[p]);
                  if (h == 0) exp_map[la + 1] = 0;
                  p++;
               end
            end
         end
      end
      exp_used = (p > LIM) ? LIM : p;
   endtask

   task automatic check_map(string tag);
      for (int a = 0; a < 512; a++) begin
         map_raddr = 9'(a);
         @(negedge clk);
         checks++;
         if (int'(map_rdata) != exp_map[a]) begin
            errors++;
            $display("FAIL %s map[%0d]: actual %0d expected %0d", tag, a, map_rdata, exp_map[a]);
         end
      end
   endtask

   task automatic run(string tag);
      int n = 0;
      model();
      @(negedge clk);
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      check("R2", int'(busy), 1, "busy after start");
      while (!done && n < 5000) begin
         @(negedge clk);
         n++;
      end
      check("R2", int'(done), 1, "done seen");
      check(tag, int'(empty), int'(exp_empty), "empty");
      check(tag, int'(used_count), exp_used, "used_count");
      @(negedge clk);
      check("R2", int'(done), 0, "done one cycle");
      check("R2", int'(busy), 0, "busy after done");
      check("R8", addr_q.size(), 0, "reads left unissued");
      check_map(tag);
   endtask

   initial begin
      #1_500_000;
      errors++;
      $display("FAIL watchdog: actual running expected finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      for (int a = 0; a < 512; a++) img[a] = 8'hFF;
      map_raddr = '0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1 reset state
      check("R1", int'(busy), 0, "busy");
      check("R1", int'(done), 0, "done");
      check("R1", int'(empty), 0, "empty");
      check("R1", int'(used_count), 0, "used_count");
      map_raddr = 9'd5;
      @(negedge clk);
      check("R1", int'(map_rdata), 255, "map byte 5");

      // R4 short headers, R8 stop on erased header
      img[0] = 8'h1C; img[1] = 8'h11; img[2] = 8'h22; img[3] = 8'h33; img[4] = 8'h44;
      img[5] = 8'h2E; img[6] = 8'h55; img[7] = 8'h66;
      run("R4 R8");

      // R5 extended, R6 skipped, R7 out of range, R10 last write wins
      for (int a = 0; a < 512; a++) img[a] = 8'hFF;
      img[0]  = 8'h2F; img[1]  = 8'h53;
      img[2]  = 8'hA1; img[3]  = 8'hA2; img[4] = 8'hA3; img[5] = 8'hA4;
      img[6]  = 8'h0F; img[7]  = 8'h0F;
      img[8]  = 8'h6F; img[9]  = 8'hE0;
      img[10] = 8'h3E; img[11] = 8'hB1; img[12] = 8'hB2;
      img[13] = 8'h3E; img[14] = 8'hC1; img[15] = 8'hC2;
      run("R5 R6 R7 R10");
      map_raddr = 9'd24;
      @(negedge clk);
      @(negedge clk);
      check("R10", int'(map_rdata), 8'hC1, "later record low byte");
      map_raddr = 9'd333;
      @(negedge clk);
      @(negedge clk);
      check("R5", int'(map_rdata), 8'hA2, "section 41 word 2 high");

      // R9 content limit with a truncated word
      for (int a = 0; a < 512; a++) img[a] = 8'h00;
      for (int r = 0; r * 9 < LIM; r++) begin
         for (int k = 1; k < 9; k++) img[r * 9 + k] = 8'((r * 9 + k) ^ 8'h5A);
      end
      run("R9");
      map_raddr = 9'd3;
      @(negedge clk);
      @(negedge clk);
      check("R9", int'(map_rdata), 0, "truncated high byte");

      // R3 blank array after a full map: everything erased again
      for (int a = 0; a < 512; a++) img[a] = 8'hFF;
      run("R3");

      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule